// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block holds the program counter of a 32-bit load-store RISC core and works out, every cycle, where the next instruction comes from. The decoder supplies a control class along with the raw fields of the current instruction. These fields are the 16-bit immediate, the 26-bit jump field, the destination register index, and the two register operands. From them the unit resolves conditional branches, jumps that stay within the current 256 MB region, jumps through a register, and calls that record a return address.

Branch conditions are deliberately cheap. Two-register branches only test equality or inequality. Single-register branches only look at the sign bit and at a zero test of the operand. Because of this, no magnitude comparator is spent on the condition. The only adders are the sequential increment and the branch-offset add. The return address is presented on a link-write port for the register file. The PC register advances only when the core asserts the advance enable.

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads `pc_q` with the parameter `RESET_VEC`.
- R2: For class 0 (sequential) and for any undefined class code (11 to 15), `next_pc` equals `pc_q + 4` and `link_we` stays low.
- R3: Class 1 (equal) is taken when `rs_val == rt_val`. Class 2 (not equal) is taken when they differ. When untaken, `next_pc` is `pc_q + 4`.
- R4: Classes 3 (greater than zero), 4 (greater or equal to zero), 5 (less than zero) and 6 (less or equal to zero) treat `rs_val` as a two's-complement value compared with zero. Class 3 is taken only when the value is nonzero and bit 31 is clear.
- R5: A taken branch sets `next_pc` to `pc_q + 4` plus the sign-extended `imm16` shifted left by two. A negative immediate moves the PC backwards.
- R6: Class 7 (jump) sets `next_pc` to `{pc_q[31:28], jtgt, 2'b00}`.
- R7: Class 9 (register jump) sets `next_pc` to `rs_val`.
- R8: Class 8 (jump and link) jumps as in R6 and, when `adv_en` is high, asserts `link_we` with `link_idx` = 31 and `link_val` = `pc_q + 4`.
- R9: Class 10 (register jump and link) jumps as in R7 and, when `adv_en` is high, asserts `link_we` with `link_idx` = `rd_idx` and `link_val` = `pc_q + 4`.
- R10: For classes 9 and 10, a nonzero `rs_val[1:0]` raises `misalign`. In that case `next_pc` equals `pc_q`, `link_we` stays low, and the PC does not change at the edge.
- R11: With `adv_en` low, `pc_q` holds its value and `link_we` stays low. With `adv_en` high and no misalignment, `pc_q` takes `next_pc` at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance the PC this cycle |
| ctl_class | input | 4 | Decoded control class |
| imm16 | input | 16 | Branch offset in words, signed |
| jtgt | input | 26 | Region-relative jump word address |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| rd_idx | input | 5 | Link destination for register calls |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Program counter for the next instruction |
| link_we | output | 1 | Write the return address |
| link_idx | output | 5 | Register index for the return address |
| link_val | output | 32 | Return address |
| misalign | output | 1 | Register target not word aligned |

## Verification
The properties check on every cycle that the PC holds while advance is low and that it takes the offered `next_pc` otherwise. They also check that a misaligned register target freezes the PC and suppresses the link write, that every `next_pc` is word aligned, that a direct call names register 31, and that reset loads the vector. The bench scenarios are what show that each branch condition is resolved correctly. This includes the signed zero-comparison boundaries at 0 and 0x80000000, the exact branch and region-jump arithmetic with backward offsets, and the return address value.

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000,
  parameter logic [4:0]  CALL_REG  = 5'd31
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        adv_en,
  input  logic [3:0]  ctl_class,
  input  logic [15:0] imm16,
  input  logic [25:0] jtgt,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  input  logic [4:0]  rd_idx,
  output logic [31:0] pc_q,
  output logic [31:0] next_pc,
  output logic        link_we,
  output logic [4:0]  link_idx,
  output logic [31:0] link_val,
  output logic        misalign
);

  localparam logic [3:0] C_SEQ  = 4'd0;
  localparam logic [3:0] C_EQ   = 4'd1;
  localparam logic [3:0] C_NE   = 4'd2;
  localparam logic [3:0] C_GTZ  = 4'd3;
  localparam logic [3:0] C_GEZ  = 4'd4;
  localparam logic [3:0] C_LTZ  = 4'd5;
  localparam logic [3:0] C_LEZ  = 4'd6;
  localparam logic [3:0] C_J    = 4'd7;
  localparam logic [3:0] C_JL   = 4'd8;
  localparam logic [3:0] C_JR   = 4'd9;
  localparam logic [3:0] C_JRL  = 4'd10;

  logic [31:0] pc_inc, br_tgt, reg_tgt, rgn_tgt;
  logic        rs_neg, rs_zero, taken, is_reg, is_call;

  assign pc_inc  = pc_q + 32'd4;
  assign br_tgt  = pc_inc + {{14{imm16[15]}}, imm16, 2'b00};
  assign rgn_tgt = {pc_q[31:28], jtgt, 2'b00};
  assign reg_tgt = rs_val;

  assign rs_neg  = rs_val[31];
  assign rs_zero = (rs_val == 32'd0);

  always_comb begin
    case (ctl_class)
      C_EQ:    taken = (rs_val == rt_val);
      C_NE:    taken = (rs_val != rt_val);
      C_GTZ:   taken = !rs_neg && !rs_zero;
      C_GEZ:   taken = !rs_neg;
      C_LTZ:   taken = rs_neg;
      C_LEZ:   taken = rs_neg || rs_zero;
      default: taken = 1'b0;
    endcase
  end

  assign is_reg   = (ctl_class == C_JR) || (ctl_class == C_JRL);
  assign misalign = is_reg && (reg_tgt[1:0] != 2'b00);

  always_comb begin
    case (ctl_class)
      C_EQ, C_NE, C_GTZ, C_GEZ, C_LTZ, C_LEZ:
               next_pc = taken ? br_tgt : pc_inc;
      C_J, C_JL:
               next_pc = rgn_tgt;
      C_JR, C_JRL:
               next_pc = misalign ? pc_q : reg_tgt;
      default: next_pc = pc_inc;
    endcase
  end

  assign is_call  = (ctl_class == C_JL) || (ctl_class == C_JRL);
  assign link_we  = adv_en && is_call && !misalign;
  assign link_idx = (ctl_class == C_JL) ? CALL_REG : rd_idx;
  assign link_val = pc_inc;

  always_ff @(posedge clk) begin
    if (rst)
      pc_q <= RESET_VEC;
    else if (adv_en && !misalign)
      pc_q <= next_pc;
  end

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
  input logic        clk,
  input logic        rst,
  input logic        adv_en,
  input logic [3:0]  ctl_class,
  input logic [31:0] pc_q,
  input logic [31:0] next_pc,
  input logic        link_we,
  input logic [4:0]  link_idx,
  input logic        misalign
);

  // R1
  reset_vec_chk: assert property (@(posedge clk) rst |=> pc_q == RESET_VEC);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> $stable(pc_q));

  // R11
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !misalign) |=> pc_q == $past(next_pc));

  // R11
  link_gate_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> adv_en);

  // R10
  misalign_chk: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (next_pc == pc_q) && !link_we);

  // R10
  misalign_hold_chk: assert property (@(posedge clk) disable iff (rst)
    misalign |=> $stable(pc_q));

  // R5
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    next_pc[1:0] == 2'b00);

  // R8
  call_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (link_we && ctl_class == 4'd8) |-> link_idx == 5'd31);

endmodule

bind npc_unit npc_unit_chk #(.RESET_VEC(RESET_VEC)) u_chk (
  .clk(clk), .rst(rst), .adv_en(adv_en), .ctl_class(ctl_class),
  .pc_q(pc_q), .next_pc(next_pc), .link_we(link_we),
  .link_idx(link_idx), .misalign(misalign)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
  localparam logic [31:0] RV = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_en = 1'b0;
  logic [3:0]  ctl_class = '0;
  logic [15:0] imm16 = '0;
  logic [25:0] jtgt = '0;
  logic [31:0] rs_val = '0, rt_val = '0;
  logic [4:0]  rd_idx = '0;
  logic [31:0] pc_q, next_pc, link_val;
  logic        link_we, misalign;
  logic [4:0]  link_idx;

  int checks = 0, fails = 0;
  logic [31:0] mpc;
  bit done = 0;

  always #5 clk = ~clk;

  npc_unit #(.RESET_VEC(RV)) u0 (
    .clk(clk), .rst(rst), .adv_en(adv_en), .ctl_class(ctl_class),
    .imm16(imm16), .jtgt(jtgt), .rs_val(rs_val), .rt_val(rt_val),
    .rd_idx(rd_idx), .pc_q(pc_q), .next_pc(next_pc), .link_we(link_we),
    .link_idx(link_idx), .link_val(link_val), .misalign(misalign)
  );

  function automatic bit f_taken(logic [3:0] c, logic [31:0] a, logic [31:0] b);
    case (c)
      4'd1: return a == b;
      4'd2: return a != b;
      4'd3: return $signed(a) > 0;
      4'd4: return $signed(a) >= 0;
      4'd5: return $signed(a) < 0;
      4'd6: return $signed(a) <= 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit f_mis(logic [3:0] c, logic [31:0] a);
    return (c == 4'd9 || c == 4'd10) && (a % 4 != 0);
  endfunction

  function automatic logic [31:0] f_next(logic [31:0] pc, logic [3:0] c,
      logic [15:0] im, logic [25:0] t, logic [31:0] a, logic [31:0] b);
    logic [31:0] off;
    off = 32'($signed(im)) * 4;
    if (c >= 4'd1 && c <= 4'd6) return f_taken(c, a, b) ? pc + 4 + off : pc + 4;
    if (c == 4'd7 || c == 4'd8) return (pc & 32'hF000_0000) | (32'(t) * 4);
    if (c == 4'd9 || c == 4'd10) return f_mis(c, a) ? pc : a;
    return pc + 4;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(logic [3:0] c, logic [15:0] im, logic [25:0] t,
      logic [31:0] a, logic [31:0] b, logic [4:0] rd, bit en, string req);
    logic [31:0] en_pc;
    bit ewe, emis;
    @(negedge clk);
    ctl_class = c; imm16 = im; jtgt = t; rs_val = a; rt_val = b;
    rd_idx = rd; adv_en = en;
    #1;
    en_pc = f_next(mpc, c, im, t, a, b);
    emis = f_mis(c, a);
    ewe  = en && (c == 4'd8 || (c == 4'd10 && !emis));
    chk(next_pc == en_pc, req, "next_pc", next_pc, en_pc);
    chk(misalign == emis, req, "misalign", 32'(misalign), 32'(emis));
    chk(link_we == ewe, req, "link_we", 32'(link_we), 32'(ewe));
    if (ewe) begin
      chk(link_idx == (c == 4'd8 ? 5'd31 : rd), req, "link_idx",
          32'(link_idx), 32'(c == 4'd8 ? 5'd31 : rd));
      chk(link_val == mpc + 4, req, "link_val", link_val, mpc + 4);
    end
    @(posedge clk); #1;
    if (en && !emis) mpc = en_pc;
    chk(pc_q == mpc, req, "pc_q", pc_q, mpc);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(posedge clk);
    #1;
    chk(pc_q == RV, "R1", "reset pc", pc_q, RV);
    @(negedge clk); rst = 1'b0;
    mpc = RV;

    step(4'd0, 16'h0, 26'h0, 0, 0, 0, 1, "R2");
    step(4'd13, 16'h7, 26'h5, 0, 0, 0, 1, "R2");
    step(4'd1, 16'h0003, 26'h0, 32'h55, 32'h55, 0, 1, "R3");
    step(4'd1, 16'h0003, 26'h0, 32'h55, 32'h56, 0, 1, "R3");
    step(4'd2, 16'hFFFE, 26'h0, 32'h1, 32'h2, 0, 1, "R3 R5");
    step(4'd3, 16'h0010, 26'h0, 32'h0, 0, 0, 1, "R4");
    step(4'd3, 16'h0010, 26'h0, 32'h8000_0000, 0, 0, 1, "R4");
    step(4'd3, 16'h0010, 26'h0, 32'h1, 0, 0, 1, "R4");
    step(4'd6, 16'hFFF0, 26'h0, 32'h0, 0, 0, 1, "R4 R5");
    step(4'd4, 16'h0004, 26'h0, 32'h0, 0, 0, 1, "R4");
    step(4'd5, 16'h0004, 26'h0, 32'h0, 0, 0, 1, "R4");
    step(4'd7, 16'h0, 26'h3FF_FFFF, 0, 0, 0, 1, "R6");
    step(4'd8, 16'h0, 26'h000_0100, 0, 0, 0, 1, "R8");
    step(4'd9, 16'h0, 26'h0, 32'hA000_1000, 0, 0, 1, "R7");
    step(4'd10, 16'h0, 26'h0, 32'h0040_0020, 0, 5'd7, 1, "R9");
    step(4'd10, 16'h0, 26'h0, 32'h0040_0022, 0, 5'd7, 1, "R10");
    step(4'd9, 16'h0, 26'h0, 32'h0040_0001, 0, 0, 1, "R10");
    step(4'd8, 16'h0, 26'h0001234, 0, 0, 0, 0, "R11");
    step(4'd0, 16'h0, 26'h0, 0, 0, 0, 0, "R11");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      logic [3:0] c;
      c = 4'($urandom_range(0, 15));
      a = $urandom;
      if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
      if ($urandom_range(0, 5) == 0) a = 32'd0;
      b = ($urandom_range(0, 1) != 0) ? a : $urandom;
      step(c, 16'($urandom), 26'($urandom), a, b, 5'($urandom),
           $urandom_range(0, 7) != 0, "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11");
    end

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk(pc_q == RV, "R1", "re-reset pc", pc_q, RV);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule